// File: doc/BRIEF.md
# External Bus Chip Select Generator

This block drives a set of active-low chip select lines for a multiplexed external bus. Every channel has its own address window, given as a base and a power-of-two size. Every channel also has a two-bit mode that sets its behaviour. When the address latch enable strobe falls, the block decodes the bus address and picks the lowest-numbered enabled channel whose window contains that address. That channel owns the bus cycle.

A channel in address mode asserts its line at that ALE fall. The line then stays asserted through later cycles to the same window. It releases only at the ALE fall of a cycle that goes elsewhere, either to another channel or to no window at all. A channel in one of the gated modes asserts its line only while the matching strobe is active: read, write (either byte half), or both. All outputs come from flip-flops, so a line can only change at a clock edge and cannot glitch.

During reset every line is high and undriven. After reset, line 0 acts as an address select for the first fetch until the first ALE fall, unless the single-chip flag is set. Disabled channels are left undriven. While the bus-hold acknowledge is active, every line is forced high.

Top module: `cs_gen`

## Requirements
- R1: While `rst_n` is low, every `cs_n_o` bit is 1 and every `cs_oe_o` bit is 0.
- R2: From the first clock edge after reset until the first ALE fall, `cs_n_o[0]` is 0 and `cs_oe_o[0]` is 1. If `single_chip_i` is 1, every line stays high instead.
- R3: Channel c's window contains address A when A and its base agree in every bit at or above position `size` (field `win_size_i[SZW*c +: SZW]`). A size of AW or more matches every address.
- R4: When several enabled windows contain the address, the lowest-numbered channel owns the cycle. An address that lies in no enabled window selects no channel.
- R5: The mode of channel c is `mode_i[2c+1:2c]`: 00 address, 01 read, 10 write, 11 read/write.
- R6: An ALE fall is a clock edge at which `ale_i` was 1 at the previous edge and is 0 now. In address mode the owning line goes low at that edge and stays low until an ALE fall that selects a different channel or none.
- R7: In read mode the owning line is low exactly one cycle after each cycle in which `rd_i` is 1.
- R8: In write mode the owning line is low one cycle after each cycle in which `wrh_i` or `wrl_i` is 1.
- R9: In read/write mode the owning line is low one cycle after each cycle in which any of `rd_i`, `wrh_i` or `wrl_i` is 1.
- R10: A channel with `chan_en_i[c]`=0 is left out of the decode, and its line stays high with `cs_oe_o[c]`=0. Enabled channels have `cs_oe_o[c]`=1 after reset.
- R11: One cycle after `hold_ack_i` is 1, every line is high and `cs_oe_o` keeps its value. After the hold ends, the held select comes back.
- R12: At most one `cs_n_o` bit is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_chip_i | input | 1 | Suppresses the boot select on line 0 |
| ale_i | input | 1 | Address latch enable, active high |
| rd_i | input | 1 | Read strobe active |
| wrh_i | input | 1 | High-byte write strobe active |
| wrl_i | input | 1 | Low-byte write strobe active |
| addr_i | input | AW | Bus address, valid at the ALE fall |
| chan_en_i | input | NCH | Per-channel enable |
| win_base_i | input | NCH*AW | Per-channel window base |
| win_size_i | input | NCH*SZW | Per-channel log2 window size |
| mode_i | input | 2*NCH | Per-channel mode field |
| hold_ack_i | input | 1 | Bus hold acknowledge |
| cs_n_o | output | NCH | Active-low chip selects |
| cs_oe_o | output | NCH | Per-line drive enable |

## Verification
The bench uses four channels on an 8-bit bus. Two of the windows overlap, and one band of addresses falls in no window. It applies every address with each of the three strobe types: read, high-byte write and low-byte write. The mode assignment is rotated so that every channel runs in every mode. Each bus cycle is checked in three phases: ALE high, strobe active, and strobe released. These phases separate a line that is held from one that is gated, a read from a write, and the winner of an overlap from the loser, and they show a release caused by an unmapped address. Directed runs add the reset and boot behaviour in both single-chip settings, a hold during a held select, and a disabled channel inside the overlap.

// File: rtl/cs_gen_pkg.sv
package cs_gen_pkg;
  typedef enum logic [1:0] {
    CSM_ADDR  = 2'b00,
    CSM_READ  = 2'b01,
    CSM_WRITE = 2'b10,
    CSM_RDWR  = 2'b11
  } cs_mode_e;
endpackage

// File: rtl/cs_win_match.sv
module cs_win_match #(
  parameter int AW  = 24,
  parameter int SZW = 5
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [AW-1:0]  base_i,
  input  logic [SZW-1:0] size_i,
  output logic           hit_o
);
  logic [AW-1:0] bit_ok;

  // bits below the window size are ignored, the rest must agree
  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign bit_ok[b] = (addr_i[b] == base_i[b]) || (SZW'(b) < size_i);
  end

  assign hit_o = &bit_ok;
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  logic found;

  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_line_ctrl.sv
module cs_line_ctrl
  import cs_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_i,
  input  logic     ale_fall_i,
  input  cs_mode_e mode_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     boot_i,
  input  logic     hold_i,
  input  logic     en_i,
  output logic     cs_n_o,
  output logic     oe_o
);
  logic strobe_ok;
  logic cs_act;
  logic cs_n_d;
  logic oe_d;

  always_comb begin
    unique case (mode_i)
      CSM_ADDR:  strobe_ok = 1'b1;
      CSM_READ:  strobe_ok = rd_i;
      CSM_WRITE: strobe_ok = wr_i;
      default:   strobe_ok = rd_i | wr_i;
    endcase
    cs_act = !hold_i && (boot_i || (sel_i && strobe_ok));
    cs_n_d = ~cs_act;
    oe_d   = en_i | boot_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_o <= 1'b1;
      oe_o   <= 1'b0;
    end else begin
      cs_n_o <= cs_n_d;
      oe_o   <= oe_d;
    end
  end

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CSM_ADDR && !ale_fall_i && !hold_i && !cs_n_o) |=> !cs_n_o);

  // R7
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(mode_i) == CSM_READ && !$past(boot_i)) |-> $past(rd_i));

  // R8
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(mode_i) == CSM_WRITE && !$past(boot_i)) |-> $past(wr_i));
endmodule

// File: rtl/cs_gen.sv
module cs_gen
  import cs_gen_pkg::*;
#(
  parameter  int NCH = 5,
  parameter  int AW  = 24,
  localparam int SZW = $clog2(AW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               single_chip_i,
  input  logic               ale_i,
  input  logic               rd_i,
  input  logic               wrh_i,
  input  logic               wrl_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [NCH-1:0]     chan_en_i,
  input  logic [NCH*AW-1:0]  win_base_i,
  input  logic [NCH*SZW-1:0] win_size_i,
  input  logic [2*NCH-1:0]   mode_i,
  input  logic               hold_ack_i,
  output logic [NCH-1:0]     cs_n_o,
  output logic [NCH-1:0]     cs_oe_o
);
  logic           ale_q;
  logic           ale_fall;
  logic [NCH-1:0] win_hit;
  logic [NCH-1:0] req;
  logic [NCH-1:0] grant;
  logic [NCH-1:0] sel_q;
  logic [NCH-1:0] sel_d;
  logic           boot_q;
  logic           boot_d;
  logic           boot_line;
  logic           wr_any;

  assign wr_any = wrh_i | wrl_i;

  for (genvar c = 0; c < NCH; c++) begin : g_win
    cs_win_match #(.AW(AW), .SZW(SZW)) u_match (
      .addr_i (addr_i),
      .base_i (win_base_i[AW*c +: AW]),
      .size_i (win_size_i[SZW*c +: SZW]),
      .hit_o  (win_hit[c])
    );
  end

  assign req = win_hit & chan_en_i;

  cs_prio_pick #(.N(NCH)) u_pick (
    .req_i   (req),
    .grant_o (grant)
  );

  always_comb begin
    ale_fall  = ale_q & ~ale_i;
    sel_d     = ale_fall ? grant : sel_q;
    boot_d    = boot_q & ~ale_fall;
    boot_line = boot_d & ~single_chip_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      sel_q  <= '0;
      boot_q <= 1'b1;
    end else begin
      ale_q <= ale_i;
      if (ale_fall) begin
        sel_q  <= grant;
        boot_q <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_line
    logic line_boot;
    if (c == 0) begin : g_boot
      assign line_boot = boot_line;
    end else begin : g_noboot
      assign line_boot = 1'b0;
    end

    cs_line_ctrl u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (sel_d[c]),
      .ale_fall_i (ale_fall),
      .mode_i     (cs_mode_e'(mode_i[2*c +: 2])),
      .rd_i       (rd_i),
      .wr_i       (wr_any),
      .boot_i     (line_boot),
      .hold_i     (hold_ack_i),
      .en_i       (chan_en_i[c]),
      .cs_n_o     (cs_n_o[c]),
      .oe_o       (cs_oe_o[c])
    );
  end

  // R12
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o));

  // R11
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_ack_i) |-> (&cs_n_o));

  // R10
  undriven_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cs_oe_o & ~cs_n_o) == '0));

  // R4
  no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_fall && req == '0 && !hold_ack_i) |=> (&cs_n_o));
endmodule

// File: tb/cs_gen_bench.sv
module cs_gen_bench;
  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam int SZW = 4;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               single_chip;
  logic               ale, rd, wrh, wrl;
  logic [AW-1:0]      addr;
  logic [NCH-1:0]     en;
  logic [NCH*AW-1:0]  base_v;
  logic [NCH*SZW-1:0] size_v;
  logic [2*NCH-1:0]   mode_v;
  logic               hold;
  logic [NCH-1:0]     cs_n, cs_oe;

  cs_gen #(.NCH(NCH), .AW(AW)) u_cs_gen (
    .clk(clk), .rst_n(rst_n), .single_chip_i(single_chip),
    .ale_i(ale), .rd_i(rd), .wrh_i(wrh), .wrl_i(wrl), .addr_i(addr),
    .chan_en_i(en), .win_base_i(base_v), .win_size_i(size_v),
    .mode_i(mode_v), .hold_ack_i(hold), .cs_n_o(cs_n), .cs_oe_o(cs_oe)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  int base_a [NCH] = '{8'h00, 8'h40, 8'h48, 8'h80};
  int size_a [NCH] = '{6, 4, 3, 7};
  int mode_of[NCH];
  int cur_sel = -1;
  bit boot    = 1'b0;

  function automatic int winner(int a);
    for (int c = 0; c < NCH; c++) begin
      if (en[c] && (a >> size_a[c]) == (base_a[c] >> size_a[c])) return c;
    end
    return -1;
  endfunction

  function automatic logic [NCH-1:0] exp_cs(bit r, bit w);
    logic [NCH-1:0] v = '1;
    for (int c = 0; c < NCH; c++) begin
      bit on = (c == cur_sel) && (mode_of[c] == 0 || (mode_of[c] == 1 && r) ||
               (mode_of[c] == 2 && w) || (mode_of[c] == 3 && (r || w)));
      if (c == 0 && boot && !single_chip) on = 1'b1;
      if (!hold && on) v[c] = 1'b0;
    end
    return v;
  endfunction

  function automatic logic [NCH-1:0] exp_oe();
    logic [NCH-1:0] v = en;
    if (boot && !single_chip) v[0] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag, logic [NCH-1:0] ecs, logic [NCH-1:0] eoe);
    vectors++;
    if (cs_n !== ecs || cs_oe !== eoe) begin
      errors++;
      $display("FAIL %s: cs_n=%b oe=%b expected cs_n=%b oe=%b (addr=%h sel=%0d)",
               tag, cs_n, cs_oe, ecs, eoe, addr, cur_sel);
    end
  endtask

  task automatic set_modes(int r);
    for (int c = 0; c < NCH; c++) begin
      mode_of[c] = (c + r) % 4;
      mode_v[2*c +: 2] = 2'(mode_of[c]);
    end
  endtask

  function automatic string tag_for(int s);
    if (s < 0) return "R3 R4";
    case (mode_of[s])
      0: return "R5 R6";
      1: return "R5 R7";
      2: return "R5 R8";
      default: return "R5 R9";
    endcase
  endfunction

  // kind: 0 read, 1 high-byte write, 2 low-byte write
  task automatic bus_cycle(int a, int kind);
    bit r = (kind == 0);
    bit w = (kind != 0);
    @(negedge clk); addr = AW'(a); ale = 1'b1;
    @(negedge clk);
    check("R6 R12 ale-high", exp_cs(0, 0), exp_oe());
    ale = 1'b0;
    @(negedge clk);
    cur_sel = winner(a);
    boot = 1'b0;
    check({tag_for(cur_sel), " R3 R4 decode"}, exp_cs(0, 0), exp_oe());
    rd = r; wrh = (kind == 1); wrl = (kind == 2);
    @(negedge clk);
    check({tag_for(cur_sel), " R12 strobe"}, exp_cs(r, w), exp_oe());
    rd = 1'b0; wrh = 1'b0; wrl = 1'b0;
    @(negedge clk);
    check({tag_for(cur_sel), " release"}, exp_cs(0, 0), exp_oe());
  endtask

  task automatic do_reset(bit sc);
    single_chip = sc;
    rst_n = 1'b0;
    cur_sel = -1;
    repeat (3) @(negedge clk);
    check("R1 reset", '1, '0);
    rst_n = 1'b1;
    boot = 1'b1;
    @(negedge clk);
    check("R2 boot", exp_cs(0, 0), exp_oe());
    @(negedge clk);
    check("R2 boot hold", exp_cs(0, 0), exp_oe());
  endtask

  initial begin
    ale = 0; rd = 0; wrh = 0; wrl = 0; hold = 0; addr = '0;
    en = '1;
    for (int c = 0; c < NCH; c++) begin
      base_v[AW*c +: AW]   = AW'(base_a[c]);
      size_v[SZW*c +: SZW] = SZW'(size_a[c]);
    end
    set_modes(0);

    do_reset(1'b1);
    bus_cycle(8'h90, 0);
    do_reset(1'b0);

    // R5 R6 R7 R8 R9: every address, every strobe, every mode per channel
    for (int r = 0; r < 4; r++) begin
      set_modes(r);
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 3; k++) bus_cycle(a, k);
      end
    end

    // R11: hold during a held address select
    set_modes(0);
    bus_cycle(8'h10, 0);
    @(negedge clk); hold = 1'b1;
    @(negedge clk);
    check("R11 hold", exp_cs(0, 0), exp_oe());
    hold = 1'b0;
    @(negedge clk);
    check("R11 hold release", exp_cs(0, 0), exp_oe());

    // R10: disabled channel inside the overlap
    en = 4'b1101;
    @(negedge clk);
    check("R10 oe", exp_cs(0, 0), exp_oe());
    for (int k = 0; k < 3; k++) bus_cycle(8'h48, k);
    for (int k = 0; k < 3; k++) bus_cycle(8'h44, k);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule